// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for an 8-bit processor core: two external request pins, two timer overflow events and a serial port request formed from a receive flag and a transmit flag. Each source has its own enable bit, and a global enable bit gates all of them. A priority bit places each source at a high or a low level. Within one level a fixed polling order decides the winner.

The controller presents one registered request and a fixed code address to the core. The addresses are eight bytes apart. When the core takes the request it pulses an acknowledge. The controller then records the level as in service and clears the flags it owns. A return strobe closes the most important active service level. A high-level request can interrupt a low-level handler. Nothing can interrupt a handler at the same level or above.

Each external pin is active low. A type bit selects whether the pin is sampled as a level or whether a falling edge is latched into a flag.

Top module: `irq_ctrl`

## Requirements
- R1: The presented address depends on the winning source index: index 0 (external 0) gives 0x0003, index 1 (timer 0) gives 0x000B, index 2 (external 1) gives 0x0013, index 3 (timer 1) gives 0x001B, and index 4 (serial) gives 0x0023.
- R2: After a synchronous reset there is no request, no level is in service, and all timer and edge flags are clear.
- R3: A source is requested only when `en_reg[7]` is 1 and its own enable bit is 1. The enable bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. Bits 5 and 6 have no effect.
- R4: `pri_reg` uses the same bit positions as the enable bits, and a 1 means high level. An enabled high-level request wins over any low-level request, whatever their polling order.
- R5: Among enabled requests at the same level, the lowest index wins. The order is external 0, timer 0, external 1, timer 1, serial.
- R6: While a low level is in service, only high-level requests are presented. While the high level is in service, no request is presented.
- R7: A `reti` pulse clears the high in-service bit if it is set, and clears the low in-service bit otherwise.
- R8: An acknowledge while `irq_req` is 1 sets the in-service bit of the presented level. It clears that source's timer flag, or its edge flag when the source is an external pin in edge mode. `irq_req` is 0 in the cycle after the acknowledge.
- R9: The serial request is `ser_rx | ser_tx` and is not cleared by an acknowledge. The request is presented again once the level it was taken at is released.
- R10: With `ext_type[i]`=1, a high-to-low transition on `ext_n[i]` sets `ext_flag[i]`. The flag requests service until it is acknowledged. With `ext_type[i]`=0, the request follows a low level on the pin, and an acknowledge does not clear it.
- R11: If a timer overflow pulse or an edge arrives in the same cycle as the acknowledge that would clear that flag, the flag stays set. If `ack` and `reti` occur in the same cycle, the return clears the level that was active before the cycle, and the acknowledge then sets the newly taken level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_reg | input | 8 | Global enable (bit 7) and per-source enables (bits 4..0) |
| pri_reg | input | 5 | Per-source level, 1 = high |
| ext_n | input | 2 | External request pins, active low |
| ext_type | input | 2 | Per-pin mode: 1 = falling edge, 0 = low level |
| tmr_ovf | input | 2 | One-cycle timer overflow pulses |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| ack | input | 1 | Core takes the presented request |
| reti | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Registered request to the core |
| irq_vec | output | 16 | Registered code address of the request |
| in_svc | output | 2 | In-service bits, bit 1 high level, bit 0 low level |
| tmr_flag | output | 2 | Timer overflow flags |
| ext_flag | output | 2 | Latched edge flags of the external pins |

## Verification
Two pairs of events can land on the same clock edge. The first pair is an acknowledge and the hardware event that sets the flag being cleared. The second pair is an acknowledge and a return. The bench provokes the first pair by driving `ack` and a timer overflow pulse on the same edge, then checks that `tmr_flag` is still set. It provokes the second pair by returning from a low-level handler on the very edge that takes a high-level preemption, then checks that `in_svc` reads high-only. A random phase compares every presented address and every in-service state against a bench model of flags and levels.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 5;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] SRC_EXT0 = 3'd0;
  localparam logic [IDX_W-1:0] SRC_TMR0 = 3'd1;
  localparam logic [IDX_W-1:0] SRC_EXT1 = 3'd2;
  localparam logic [IDX_W-1:0] SRC_TMR1 = 3'd3;
  localparam logic [IDX_W-1:0] SRC_SER  = 3'd4;

  typedef struct packed {
    logic             valid;
    logic             lvl;
    logic [IDX_W-1:0] idx;
  } pick_t;
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int NEXT = 2,
  parameter int NTMR = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NEXT-1:0] ext_type,
  input  logic [NTMR-1:0] tmr_ovf,
  input  logic [NEXT-1:0] clr_ext,
  input  logic [NTMR-1:0] clr_tmr,
  output logic [NEXT-1:0] ext_req,
  output logic [NEXT-1:0] ext_flag,
  output logic [NTMR-1:0] tmr_flag
);
  genvar g;

  for (g = 0; g < NEXT; g++) begin : g_ext
    logic pin_q, pin_prev, fall;

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_q    <= 1'b1;
        pin_prev <= 1'b1;
      end else begin
        pin_q    <= ext_n[g];
        pin_prev <= pin_q;
      end
    end

    assign fall = pin_prev & ~pin_q;

    // a new edge outranks a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst) ext_flag[g] <= 1'b0;
      else     ext_flag[g] <= (ext_flag[g] & ~clr_ext[g]) | (fall & ext_type[g]);
    end

    assign ext_req[g] = ext_type[g] ? ext_flag[g] : ~pin_q;
  end

  for (g = 0; g < NTMR; g++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (rst) tmr_flag[g] <= 1'b0;
      else     tmr_flag[g] <= (tmr_flag[g] & ~clr_tmr[g]) | tmr_ovf[g];
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
(
  input  logic [NSRC-1:0] elig,
  input  logic [NSRC-1:0] pri,
  input  logic [1:0]      in_svc,
  output pick_t           pick
);
  logic [1:0][NSRC-1:0]  grp;
  logic [1:0]            any;
  logic [1:0][IDX_W-1:0] first;

  assign grp[1] = elig & pri;
  assign grp[0] = elig & ~pri;

  genvar l;
  for (l = 0; l < 2; l++) begin : g_lvl
    always_comb begin
      any[l]   = |grp[l];
      first[l] = '0;
      for (int i = NSRC - 1; i >= 0; i--)
        if (grp[l][i]) first[l] = IDX_W'(i);
    end
  end

  always_comb begin
    pick = '0;
    if (any[1] && !in_svc[1]) begin
      pick.valid = 1'b1;
      pick.lvl   = 1'b1;
      pick.idx   = first[1];
    end else if (any[0] && in_svc == 2'b00) begin
      pick.valid = 1'b1;
      pick.lvl   = 1'b0;
      pick.idx   = first[0];
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       take_lvl,
  input  logic       ret,
  output logic [1:0] in_svc
);
  logic [1:0] nxt;

  always_comb begin
    nxt = in_svc;
    if (ret) begin
      if (in_svc[1]) nxt[1] = 1'b0;
      else           nxt[0] = 1'b0;
    end
    if (take) nxt[take_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) in_svc <= 2'b00;
    else     in_svc <= nxt;
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       en_reg,
  input  logic [NSRC-1:0]  pri_reg,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       ext_type,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [1:0]       in_svc,
  output logic [1:0]       tmr_flag,
  output logic [1:0]       ext_flag
);
  logic [1:0]       ext_req, clr_ext, clr_tmr;
  logic [NSRC-1:0]  pend, elig;
  pick_t            pick;
  logic             lvl_q, take;
  logic [IDX_W-1:0] idx_q;
  logic             unused_en;

  assign unused_en = ^en_reg[6:5];

  irq_src_flags #(.NEXT(2), .NTMR(2)) u_flags (
    .clk(clk), .rst(rst), .ext_n(ext_n), .ext_type(ext_type),
    .tmr_ovf(tmr_ovf), .clr_ext(clr_ext), .clr_tmr(clr_tmr),
    .ext_req(ext_req), .ext_flag(ext_flag), .tmr_flag(tmr_flag)
  );

  assign pend[SRC_EXT0] = ext_req[0];
  assign pend[SRC_TMR0] = tmr_flag[0];
  assign pend[SRC_EXT1] = ext_req[1];
  assign pend[SRC_TMR1] = tmr_flag[1];
  assign pend[SRC_SER]  = ser_rx | ser_tx;

  assign elig = en_reg[7] ? (pend & en_reg[NSRC-1:0]) : '0;

  irq_pick u_pick (.elig(elig), .pri(pri_reg), .in_svc(in_svc), .pick(pick));

  assign take = ack & irq_req;

  assign clr_tmr[0] = take && idx_q == SRC_TMR0;
  assign clr_tmr[1] = take && idx_q == SRC_TMR1;
  assign clr_ext[0] = take && idx_q == SRC_EXT0 && ext_type[0];
  assign clr_ext[1] = take && idx_q == SRC_EXT1 && ext_type[1];

  irq_level_track u_lvl (
    .clk(clk), .rst(rst), .take(take), .take_lvl(lvl_q),
    .ret(reti), .in_svc(in_svc)
  );

  // the taken request is dropped at once so a stale pick is never shown
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      lvl_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      irq_req <= take ? 1'b0 : pick.valid;
      irq_vec <= VEC_W'(VEC_BASE + VEC_STEP * int'(pick.idx));
      lvl_q   <= pick.lvl;
      idx_q   <= pick.idx;
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  en_reg,
  input logic        ack,
  input logic        reti,
  input logic        irq_req,
  input logic [15:0] irq_vec,
  input logic [1:0]  in_svc
);
  assert_vec_legal_R1: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec < 16'h0028));

  assert_reset_clean_R2: assert property (@(posedge clk)
    rst |=> (!irq_req && in_svc == 2'b00));

  assert_global_gate_R3: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(en_reg[7]));

  assert_high_blocks_all_R6: assert property (@(posedge clk) disable iff (rst)
    $past(in_svc[1]) |-> !irq_req);

  assert_no_low_under_high_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(in_svc[1]) && in_svc[0]) |-> $past(in_svc[0]));

  assert_reti_top_first_R7: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack && in_svc == 2'b11) |=> in_svc == 2'b01);

  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_req) |=> !irq_req);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .en_reg(en_reg), .ack(ack), .reti(reti),
  .irq_req(irq_req), .irq_vec(irq_vec), .in_svc(in_svc)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  en_reg = '0;
  logic [4:0]  pri_reg = '0;
  logic [1:0]  ext_n = 2'b11, ext_type = 2'b00, tmr_ovf = 2'b00;
  logic        ser_rx = 1'b0, ser_tx = 1'b0, ack = 1'b0, reti = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [1:0]  in_svc, tmr_flag, ext_flag;
  int          n_tests = 0, n_fail = 0;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst(rst), .en_reg(en_reg), .pri_reg(pri_reg), .ext_n(ext_n),
    .ext_type(ext_type), .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
    .in_svc(in_svc), .tmr_flag(tmr_flag), .ext_flag(ext_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [15:0] exp);
    check(irq_req && irq_vec == exp, tag, {irq_req, irq_vec}, {1'b1, exp});
  endtask

  task automatic chk_none(input string tag);
    check(!irq_req, tag, irq_req, 0);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; en_reg = '0; pri_reg = '0; ext_n = 2'b11; ext_type = 2'b00;
    tmr_ovf = '0; ser_rx = 0; ser_tx = 0; ack = 0; reti = 0;
    cyc(2);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic do_ack;
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic do_reti;
    reti = 1'b1; cyc(1); reti = 1'b0;
  endtask

  task automatic pulse_tmr(input int i);
    tmr_ovf[i] = 1'b1; cyc(1); tmr_ovf = '0;
  endtask

  // expected {req, lvl, idx[2:0]}
  function automatic logic [4:0] model_pick(logic [4:0] pend, logic [7:0] en,
                                            logic [4:0] pri, logic [1:0] svc);
    logic [4:0] el;
    logic [4:0] r;
    el = en[7] ? (pend & en[4:0]) : 5'b0;
    r  = '0;
    if (!svc[1])
      for (int i = 4; i >= 0; i--) if (el[i] && pri[i]) r = {2'b11, 3'(i)};
    if (!r[4] && svc == 2'b00)
      for (int i = 4; i >= 0; i--) if (el[i] && !pri[i]) r = {2'b10, 3'(i)};
    return r;
  endfunction

  function automatic logic [15:0] vec_of(logic [2:0] idx);
    return 16'(3 + 8 * int'(idx));
  endfunction

  initial begin
    logic [1:0] m_tf, m_svc;
    logic [4:0] pend, exp;
    void'($urandom(32'd20250611));
    cyc(3);
    rst = 1'b0;
    cyc(1);

    // R2 reset state
    check(!irq_req && in_svc == 0 && tmr_flag == 0 && ext_flag == 0, "R2 reset",
          {irq_req, in_svc, tmr_flag, ext_flag}, 0);

    // R3 gating: everything pending
    ext_n = 2'b00; ser_rx = 1'b1;
    pulse_tmr(0); pulse_tmr(1);
    en_reg = 8'h1F; cyc(4); chk_none("R3 no global");
    en_reg = 8'h80; cyc(4); chk_none("R3 no source enable");
    en_reg = 8'hE0; cyc(4); chk_none("R3 bits 5-6 ignored");

    // R5 fixed order and R1 addresses
    en_reg = 8'h9F; cyc(4); chk_vec("R5 R1 ext0 first", 16'h0003);
    en_reg = 8'h9E; cyc(4); chk_vec("R5 R1 timer0 next", 16'h000B);
    en_reg = 8'h9C; cyc(4); chk_vec("R5 R1 ext1 next", 16'h0013);
    en_reg = 8'h98; cyc(4); chk_vec("R5 R1 timer1 next", 16'h001B);
    en_reg = 8'h90; cyc(4); chk_vec("R5 R1 serial last", 16'h0023);

    // R4 high level wins
    en_reg = 8'h9F; pri_reg = 5'b10000; cyc(4); chk_vec("R4 serial high", 16'h0023);
    pri_reg = 5'b00100; cyc(4); chk_vec("R4 ext1 high", 16'h0013);

    // R6 / R7 preemption and return
    do_reset;
    en_reg = 8'h89; pri_reg = 5'b01000; ext_n = 2'b10;
    cyc(4); chk_vec("R6 low ext0", 16'h0003);
    do_ack; chk_none("R8 drop after ack");
    cyc(1); check(in_svc == 2'b01, "R8 low in service", in_svc, 2'b01);
    cyc(3); chk_none("R6 low blocks low");
    pulse_tmr(1); cyc(4); chk_vec("R6 high preempts", 16'h001B);
    do_ack; check(in_svc == 2'b11 && tmr_flag[1] == 0, "R8 timer cleared",
                  {in_svc, tmr_flag}, 5'b11_00);
    do_reti; check(in_svc == 2'b01, "R7 high cleared first", in_svc, 2'b01);
    cyc(3); chk_none("R6 still low in service");
    do_reti; check(in_svc == 2'b00, "R7 low cleared", in_svc, 2'b00);
    cyc(4); chk_vec("R10 level pin asks again", 16'h0003);

    // R9 serial survives ack
    do_reset;
    en_reg = 8'h90; ser_tx = 1'b1; cyc(4); chk_vec("R9 serial", 16'h0023);
    do_ack; cyc(3); chk_none("R9 blocked at own level");
    do_reti; cyc(4); chk_vec("R9 serial again", 16'h0023);
    ser_tx = 1'b0;

    // R10 edge mode
    do_reset;
    ext_type = 2'b01; en_reg = 8'h81;
    ext_n[0] = 1'b0; cyc(1); ext_n[0] = 1'b1; cyc(4);
    check(ext_flag[0] == 1'b1, "R10 edge latched", ext_flag, 2'b01);
    chk_vec("R10 edge request", 16'h0003);
    do_ack; check(ext_flag[0] == 1'b0, "R10 edge flag cleared", ext_flag, 0);
    do_reti; cyc(4); chk_none("R10 no request after clear");

    // R11 same-cycle events
    do_reset;
    en_reg = 8'h8A; pri_reg = 5'b01000;
    pulse_tmr(0); cyc(4); chk_vec("R11 timer0", 16'h000B);
    ack = 1'b1; tmr_ovf[0] = 1'b1; cyc(1); ack = 1'b0; tmr_ovf = '0;
    check(tmr_flag[0] == 1'b1 && in_svc == 2'b01, "R11 set beats clear",
          {tmr_flag, in_svc}, 4'b01_01);
    pulse_tmr(1); cyc(4); chk_vec("R11 high presented", 16'h001B);
    ack = 1'b1; reti = 1'b1; cyc(1); ack = 1'b0; reti = 1'b0;
    check(in_svc == 2'b10, "R11 ack with reti", in_svc, 2'b10);
    do_reti; cyc(4); chk_vec("R11 timer0 still pending", 16'h000B);

    // random phase, level pins only
    do_reset;
    m_tf = '0; m_svc = '0;
    for (int it = 0; it < 400; it++) begin
      en_reg  = {($urandom % 5 != 0), 2'($urandom), 5'($urandom)};
      pri_reg = 5'($urandom);
      ext_n   = 2'($urandom);
      ser_rx  = ($urandom % 4 == 0);
      ser_tx  = ($urandom % 6 == 0);
      if ($urandom % 3 == 0) begin
        int t = int'($urandom % 2);
        pulse_tmr(t); m_tf[t] = 1'b1;
      end
      cyc(4);
      pend = {ser_rx | ser_tx, m_tf[1], ~ext_n[1], m_tf[0], ~ext_n[0]};
      exp  = model_pick(pend, en_reg, pri_reg, m_svc);
      check(irq_req == exp[4] && (!exp[4] || irq_vec == vec_of(exp[2:0])),
            "R1 R4 R5 R6 random pick", {irq_req, irq_vec}, {exp[4], vec_of(exp[2:0])});
      if (exp[4] && $urandom % 2 == 0) begin
        do_ack;
        m_svc[exp[3]] = 1'b1;
        if (exp[2:0] == 3'd1) m_tf[0] = 1'b0;
        if (exp[2:0] == 3'd3) m_tf[1] = 1'b0;
        chk_none("R8 random drop");
      end
      if (m_svc != 0 && $urandom % 3 == 0) begin
        do_reti;
        if (m_svc[1]) m_svc[1] = 1'b0; else m_svc[0] = 1'b0;
      end
      check(in_svc == m_svc && tmr_flag == m_tf, "R7 R8 random state",
            {in_svc, tmr_flag}, {m_svc, m_tf});
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule